// File: doc/BRIEF.md
# Multi-Retire Reorder Buffer

A circular reorder buffer that tracks in-flight micro-operations between dispatch and commit. Up to three operations enter per clock in program order, each carrying the architectural destination it will update. The slot it takes is its handle: execution units later deliver a result for a slot in any order, and the result stays in that slot until commit.

Each clock the buffer offers its oldest completed operations on three commit lanes, oldest first, as write requests to an architectural register file port. Commit halts at the first operation that has not finished. An operation whose result carries a redirect marker (a mispredicted branch or a fault) still commits, but nothing younger does: every younger slot is dropped and both ring pointers move to the slot just after it, so the correct path refills from there. Head and tail are slot indexes modulo the depth, and a separate occupancy count tells a full ring from an empty one.

Top module: `rob_multi_retire`

## Requirements
- R1: After reset the buffer is empty: `rob_count` is 0, `alloc_base` is 0, no commit lane is valid and `ret_flush` is 0.
- R2: A request of N (0..3) in a cycle without stall takes slots `alloc_base`, `alloc_base`+1, ... `alloc_base`+N-1 (modulo the depth). Lane i of `alloc_tag` (bits i*TAG_W upward) goes to slot `alloc_base`+i, and `alloc_base` advances by N at the clock edge.
- R3: `alloc_stall` is high, and nothing is allocated, when the request exceeds the free slots (depth minus `rob_count` at the start of the cycle). The occupancy never goes above the depth.
- R4: A write-back (port j: bit j of `wb_valid`, slice j of `wb_idx`/`wb_data`/`wb_mark`) to an occupied slot marks it complete and stores its result and marker. A write-back to a slot that is not occupied is ignored, so that slot is not complete once it is allocated later.
- R5: Commit lanes are filled oldest first as a contiguous run from lane 0. Up to three complete operations are presented per clock with their tag and result in the same cycle, and their slots are freed at the next edge.
- R6: Commit stops at the first operation that is not complete. No younger complete operation is presented past it.
- R7: A complete operation with its marker set is presented on its lane with `ret_flush` high, and no lane younger than it is valid. At the next edge all slots are emptied, `rob_count` becomes 0 and `alloc_base` becomes that slot plus 1 (modulo the depth). Allocation is refused (`alloc_stall` high) in that cycle.
- R8: Slot indexes wrap from depth-1 to 0 for allocation and commit alike, keeping program order across the wrap.
- R9: Outside a redirect, `rob_count` at each edge changes by the number allocated minus the number committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | REQ_W | Number of operations to enter this cycle (0..ALLOC_W) |
| alloc_tag | input | ALLOC_W*TAG_W | Destination tag per allocation lane |
| alloc_stall | output | 1 | Request refused this cycle |
| alloc_base | output | IDX_W | Slot the first allocation lane takes (ring tail) |
| wb_valid | input | NUM_WB | Write-back strobe per port |
| wb_idx | input | NUM_WB*IDX_W | Slot addressed per port |
| wb_data | input | NUM_WB*DATA_W | Result per port |
| wb_mark | input | NUM_WB | Redirect marker per port |
| ret_valid | output | RET_W | Commit lane valid, contiguous from lane 0 |
| ret_tag | output | RET_W*TAG_W | Destination tag per commit lane |
| ret_data | output | RET_W*DATA_W | Result per commit lane |
| ret_flush | output | 1 | A committing operation carries the redirect marker |
| rob_count | output | CNT_W | Occupied slots |

## Verification
A lost completion bit shows up within one clock as a commit run that stalls at an operation whose result was already delivered, or moves past one that was not. A head or tail pointer off by one shows as the wrong tag or result on lane 0 at the next commit, or as a wrong `alloc_base`. A redirect that leaves stale state shows in the cycle after the flush, as a nonzero occupancy or an early commit of a refilled slot. A wrong free-slot computation shows as a stall decision that differs from the occupancy seen at the port, in the same cycle as the request.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;

  // Ring index step: base + off, folded once into [0, depth).
  function automatic int unsigned ring_add(input int unsigned base,
                                           input int unsigned off,
                                           input int unsigned depth);
    int unsigned s;
    s = base + off;
    return (s >= depth) ? s - depth : s;
  endfunction

  // Slots still open for allocation.
  function automatic int unsigned open_slots(input int unsigned occ,
                                             input int unsigned depth);
    return (occ >= depth) ? 0 : depth - occ;
  endfunction

endpackage

// File: rtl/rob_alloc_gate.sv
`timescale 1ns/1ps
module rob_alloc_gate #(
  parameter int DEPTH = 40,
  parameter int CNT_W = 6,
  parameter int REQ_W = 2
) (
  input  logic [REQ_W-1:0] req,
  input  logic [CNT_W-1:0] occ,
  input  logic             redirect,
  output logic             stall,
  output logic             go,
  output logic [CNT_W-1:0] take_n
);
  import rob_pkg::*;

  logic [CNT_W-1:0] free_n;
  logic             too_many;

  always_comb begin
    free_n   = CNT_W'(open_slots(32'(occ), DEPTH));
    too_many = CNT_W'(req) > free_n;
    stall    = redirect || too_many;
    go       = !stall && (req != '0);
    take_n   = go ? CNT_W'(req) : '0;
  end
endmodule

// File: rtl/rob_retire_pick.sv
`timescale 1ns/1ps
module rob_retire_pick #(
  parameter int DEPTH = 40,
  parameter int RET_W = 3,
  parameter int IDX_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IDX_W-1:0]       head,
  input  logic [DEPTH-1:0]       busy,
  input  logic [DEPTH-1:0]       done,
  input  logic [DEPTH-1:0]       mark,
  output logic [RET_W-1:0]       lane_go,
  output logic [RET_W*IDX_W-1:0] lane_idx,
  output logic                   redirect,
  output logic [IDX_W-1:0]       redirect_idx
);
  import rob_pkg::*;

  logic [IDX_W-1:0] slot [RET_W];
  logic [RET_W:0]   chain;

  always_comb begin
    chain[0]     = 1'b1;
    redirect     = 1'b0;
    redirect_idx = '0;
    for (int k = 0; k < RET_W; k++) begin
      slot[k] = IDX_W'(ring_add(32'(head), 32'(k), DEPTH));
      lane_idx[k*IDX_W +: IDX_W] = slot[k];
      lane_go[k]   = chain[k] && busy[slot[k]] && done[slot[k]];
      chain[k+1]   = lane_go[k] && !mark[slot[k]];
      if (lane_go[k] && mark[slot[k]] && !redirect) begin
        redirect     = 1'b1;
        redirect_idx = slot[k];
      end
    end
  end

  // A later lane may only commit when every older lane does.
  generate
    for (genvar g = 1; g < RET_W; g++) begin : g_order
      AST_LANE_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        lane_go[g] |-> lane_go[g-1]);  // R5
    end
  endgenerate
endmodule

// File: rtl/rob_multi_retire.sv
`timescale 1ns/1ps
module rob_multi_retire #(
  parameter int DEPTH   = 40,
  parameter int ALLOC_W = 3,
  parameter int RET_W   = 3,
  parameter int NUM_WB  = 2,
  parameter int TAG_W   = 5,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int REQ_W  = $clog2(ALLOC_W + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [REQ_W-1:0]          alloc_req,
  input  logic [ALLOC_W*TAG_W-1:0]  alloc_tag,
  output logic                      alloc_stall,
  output logic [IDX_W-1:0]          alloc_base,
  input  logic [NUM_WB-1:0]         wb_valid,
  input  logic [NUM_WB*IDX_W-1:0]   wb_idx,
  input  logic [NUM_WB*DATA_W-1:0]  wb_data,
  input  logic [NUM_WB-1:0]         wb_mark,
  output logic [RET_W-1:0]          ret_valid,
  output logic [RET_W*TAG_W-1:0]    ret_tag,
  output logic [RET_W*DATA_W-1:0]   ret_data,
  output logic                      ret_flush,
  output logic [CNT_W-1:0]          rob_count
);
  import rob_pkg::*;

  // Ring state
  logic [IDX_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  count_q;
  logic [DEPTH-1:0]  busy_q, done_q, mark_q;
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  // Named internal events
  logic                   alloc_go;
  logic [CNT_W-1:0]       alloc_n;
  logic [RET_W-1:0]       lane_go;
  logic [RET_W*IDX_W-1:0] lane_idx;
  logic                   redirect;
  logic [IDX_W-1:0]       redirect_idx;
  logic [CNT_W-1:0]       ret_n;
  logic [IDX_W-1:0]       alloc_slot [ALLOC_W];
  logic [IDX_W-1:0]       restart_idx;

  rob_retire_pick #(.DEPTH(DEPTH), .RET_W(RET_W), .IDX_W(IDX_W)) u_pick (
    .clk          (clk),
    .rst_n        (rst_n),
    .head         (head_q),
    .busy         (busy_q),
    .done         (done_q),
    .mark         (mark_q),
    .lane_go      (lane_go),
    .lane_idx     (lane_idx),
    .redirect     (redirect),
    .redirect_idx (redirect_idx)
  );

  rob_alloc_gate #(.DEPTH(DEPTH), .CNT_W(CNT_W), .REQ_W(REQ_W)) u_gate (
    .req      (alloc_req),
    .occ      (count_q),
    .redirect (redirect),
    .stall    (alloc_stall),
    .go       (alloc_go),
    .take_n   (alloc_n)
  );

  always_comb begin
    ret_n = '0;
    for (int k = 0; k < RET_W; k++) begin
      ret_n = ret_n + CNT_W'(lane_go[k]);
      ret_tag [k*TAG_W  +: TAG_W]  = tag_q [lane_idx[k*IDX_W +: IDX_W]];
      ret_data[k*DATA_W +: DATA_W] = data_q[lane_idx[k*IDX_W +: IDX_W]];
    end
    for (int i = 0; i < ALLOC_W; i++)
      alloc_slot[i] = IDX_W'(ring_add(32'(tail_q), 32'(i), DEPTH));
    restart_idx = IDX_W'(ring_add(32'(redirect_idx), 32'd1, DEPTH));
  end

  assign ret_valid  = lane_go;
  assign ret_flush  = redirect;
  assign alloc_base = tail_q;
  assign rob_count  = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      busy_q  <= '0;
      done_q  <= '0;
      mark_q  <= '0;
    end else if (redirect) begin
      head_q  <= restart_idx;
      tail_q  <= restart_idx;
      count_q <= '0;
      busy_q  <= '0;
      done_q  <= '0;
      mark_q  <= '0;
    end else begin
      // results land only in occupied slots
      for (int j = 0; j < NUM_WB; j++) begin
        if (wb_valid[j] && busy_q[wb_idx[j*IDX_W +: IDX_W]]) begin
          done_q[wb_idx[j*IDX_W +: IDX_W]] <= 1'b1;
          mark_q[wb_idx[j*IDX_W +: IDX_W]] <= wb_mark[j];
          data_q[wb_idx[j*IDX_W +: IDX_W]] <= wb_data[j*DATA_W +: DATA_W];
        end
      end
      // committed slots are freed
      for (int k = 0; k < RET_W; k++) begin
        if (lane_go[k]) begin
          busy_q[lane_idx[k*IDX_W +: IDX_W]] <= 1'b0;
          done_q[lane_idx[k*IDX_W +: IDX_W]] <= 1'b0;
          mark_q[lane_idx[k*IDX_W +: IDX_W]] <= 1'b0;
        end
      end
      // new entries take free slots at the tail
      for (int i = 0; i < ALLOC_W; i++) begin
        if (CNT_W'(i) < alloc_n) begin
          busy_q[alloc_slot[i]] <= 1'b1;
          done_q[alloc_slot[i]] <= 1'b0;
          mark_q[alloc_slot[i]] <= 1'b0;
          tag_q [alloc_slot[i]] <= alloc_tag[i*TAG_W +: TAG_W];
        end
      end
      head_q  <= IDX_W'(ring_add(32'(head_q), 32'(ret_n), DEPTH));
      tail_q  <= IDX_W'(ring_add(32'(tail_q), 32'(alloc_n), DEPTH));
      count_q <= count_q + alloc_n - ret_n;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rob_count <= CNT_W'(DEPTH));  // R3
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_stall |=> rob_count <= $past(rob_count));  // R3
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (rob_count == '0) && (ret_valid == '0));  // R7
  AST_COUNT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> rob_count == $past(rob_count) + $past(alloc_n) - $past(ret_n));  // R9
  AST_RET_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid != '0) |-> (rob_count != '0));  // R5
endmodule

// File: tb/rob_multi_retire_bench.sv
`timescale 1ns/1ps
module rob_multi_retire_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 40, ALLOC_W = 3, RET_W = 3, NUM_WB = 2, TAG_W = 5, DATA_W = 32;
  localparam int IDX_W = 6, CNT_W = 6, REQ_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [REQ_W-1:0]         alloc_req;
  logic [ALLOC_W*TAG_W-1:0] alloc_tag;
  logic                     alloc_stall;
  logic [IDX_W-1:0]         alloc_base;
  logic [NUM_WB-1:0]        wb_valid;
  logic [NUM_WB*IDX_W-1:0]  wb_idx;
  logic [NUM_WB*DATA_W-1:0] wb_data;
  logic [NUM_WB-1:0]        wb_mark;
  logic [RET_W-1:0]         ret_valid;
  logic [RET_W*TAG_W-1:0]   ret_tag;
  logic [RET_W*DATA_W-1:0]  ret_data;
  logic                     ret_flush;
  logic [CNT_W-1:0]         rob_count;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rob_multi_retire u_rob_multi_retire (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_tag(alloc_tag),
    .alloc_stall(alloc_stall), .alloc_base(alloc_base),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data), .wb_mark(wb_mark),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_data(ret_data),
    .ret_flush(ret_flush), .rob_count(rob_count)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    alloc_req = '0; alloc_tag = '0;
    wb_valid = '0; wb_idx = '0; wb_data = '0; wb_mark = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  function automatic int slot_of(input int s);
    return (6 + s) % DEPTH;
  endfunction

  task automatic alloc(input int n, input int t0);
    alloc_req = REQ_W'(n);
    for (int i = 0; i < ALLOC_W; i++) alloc_tag[i*TAG_W +: TAG_W] = TAG_W'(t0 + i);
    tick();
  endtask

  task automatic wb_one(input int idx, input logic [31:0] d, input logic m);
    wb_valid = 2'b01; wb_idx[IDX_W-1:0] = IDX_W'(idx);
    wb_data[DATA_W-1:0] = d; wb_mark[0] = m;
    tick();
  endtask

  task automatic wb_two(input int i0, input logic [31:0] d0, input logic m0,
                        input int i1, input logic [31:0] d1, input logic m1);
    wb_valid = 2'b11;
    wb_idx = {IDX_W'(i1), IDX_W'(i0)};
    wb_data = {d1, d0};
    wb_mark = {m1, m0};
    tick();
  endtask

  task automatic t_reset();
    chk("R1", "count", 64'(rob_count), 0);
    chk("R1", "base", 64'(alloc_base), 0);
    chk("R1", "ret_valid", 64'(ret_valid), 0);
    chk("R1", "flush", 64'(ret_flush), 0);
    alloc_req = 2'd3; #1;
    chk("R3", "no stall when empty", 64'(alloc_stall), 0);
    idle();
  endtask

  task automatic t_alloc_and_ooo();
    alloc(3, 1);  // slots 0,1,2 tags 1,2,3
    chk("R2", "count after alloc", 64'(rob_count), 3);
    chk("R2", "base after alloc", 64'(alloc_base), 3);
    wb_one(2, 32'hC2, 1'b0);
    chk("R6", "youngest done alone", 64'(ret_valid), 0);
    wb_one(0, 32'hA0, 1'b0);
    chk("R5", "oldest commits", 64'(ret_valid), 3'b001);
    chk("R5", "lane0 tag", 64'(ret_tag[4:0]), 1);
    chk("R5", "lane0 data", 64'(ret_data[31:0]), 32'hA0);
    tick();
    chk("R9", "count after one commit", 64'(rob_count), 2);
    chk("R6", "stop at slot1", 64'(ret_valid), 0);
    wb_one(1, 32'hB1, 1'b0);
    chk("R5", "two lanes", 64'(ret_valid), 3'b011);
    chk("R5", "lane0 tag", 64'(ret_tag[4:0]), 2);
    chk("R5", "lane1 tag", 64'(ret_tag[9:5]), 3);
    chk("R4", "lane1 data", 64'(ret_data[63:32]), 32'hC2);
    tick();
    chk("R9", "empty again", 64'(rob_count), 0);
  endtask

  task automatic t_ignore_wb();
    wb_one(5, 32'h55, 1'b0);  // slot 5 not occupied
    alloc(3, 8);               // slots 3,4,5
    wb_two(3, 32'h33, 1'b0, 4, 32'h44, 1'b0);
    chk("R4", "stale write ignored", 64'(ret_valid), 3'b011);
    tick();
    chk("R9", "one left", 64'(rob_count), 1);
    wb_one(5, 32'h5A, 1'b0);
    chk("R4", "slot5 commit", 64'(ret_valid), 3'b001);
    chk("R4", "slot5 tag", 64'(ret_tag[4:0]), 10);
    chk("R4", "slot5 data", 64'(ret_data[31:0]), 32'h5A);
    tick();
    chk("R9", "empty", 64'(rob_count), 0);
    chk("R2", "base 6", 64'(alloc_base), 6);
  endtask

  task automatic t_stall();
    for (int s = 0; s < 36; s += 3) alloc(3, s);
    alloc(2, 36);
    chk("R9", "count 38", 64'(rob_count), 38);
    chk("R8", "base wrapped", 64'(alloc_base), 4);
    alloc_req = 2'd3; #1;
    chk("R3", "stall 3 of 2 free", 64'(alloc_stall), 1);
    tick();
    chk("R3", "nothing taken", 64'(rob_count), 38);
    alloc_req = 2'd2; alloc_tag = {5'd0, 5'd6, 5'd6}; #1;
    chk("R3", "2 fit", 64'(alloc_stall), 0);
    alloc_tag[9:0] = {5'd7, 5'd6};
    tick();
    chk("R3", "full", 64'(rob_count), 40);
    alloc_req = 2'd1; #1;
    chk("R3", "stall when full", 64'(alloc_stall), 1);
    tick();
    chk("R3", "still 40", 64'(rob_count), 40);
  endtask

  task automatic t_wide_retire();
    int e;
    for (int s = 39; s > 0; s -= 2) begin
      wb_two(slot_of(s), 32'hD000_0000 + 32'(s), 1'b0,
             slot_of(s-1), 32'hD000_0000 + 32'(s-1), 1'b0);
      if (s > 1) chk("R6", "oldest pending", 64'(ret_valid), 0);
    end
    e = 0;
    while (e < 40) begin
      int n;
      n = (40 - e < 3) ? 40 - e : 3;
      chk("R5", "lane mask", 64'(ret_valid), 64'((1 << n) - 1));
      for (int k = 0; k < n; k++) begin
        chk("R8", "tag order", 64'(ret_tag[k*TAG_W +: TAG_W]), 64'((e + k) % 32));
        chk("R5", "data order", 64'(ret_data[k*DATA_W +: DATA_W]),
            64'(32'hD000_0000 + 32'(e + k)));
      end
      tick();
      e += n;
    end
    chk("R9", "drained", 64'(rob_count), 0);
  endtask

  task automatic t_flush();
    alloc(3, 20);  // slots 6,7,8
    alloc(3, 23);  // slots 9,10,11
    wb_two(8, 32'h80, 1'b0, 9, 32'h90, 1'b0);
    wb_two(6, 32'h60, 1'b0, 7, 32'h70, 1'b1);
    chk("R7", "commit up to marked", 64'(ret_valid), 3'b011);
    chk("R7", "flush flag", 64'(ret_flush), 1);
    chk("R7", "marked tag", 64'(ret_tag[9:5]), 21);
    chk("R7", "marked data", 64'(ret_data[63:32]), 32'h70);
    alloc_req = 2'd1; #1;
    chk("R7", "alloc refused", 64'(alloc_stall), 1);
    tick();
    chk("R7", "count cleared", 64'(rob_count), 0);
    chk("R7", "tail after marked", 64'(alloc_base), 8);
    chk("R7", "nothing left", 64'(ret_valid), 0);
    alloc(1, 30);  // slot 8 again
    chk("R7", "old result dropped", 64'(ret_valid), 0);
    wb_one(8, 32'h88, 1'b0);
    chk("R7", "refill commits", 64'(ret_valid), 3'b001);
    chk("R7", "refill tag", 64'(ret_tag[4:0]), 30);
    chk("R7", "refill data", 64'(ret_data[31:0]), 32'h88);
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc_and_ooo();
    t_ignore_wb();
    t_stall();
    t_wide_retire();
    t_flush();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule